// File: doc/BRIEF.md
# Extended-Address Memory Window Decoder

This block decides whether a bus cycle is addressed to a 32K static-RAM card on a 24-bit extended-address bus. Which card is selected is set by configuration inputs that stand in for DIP switches. Two 8-position one-hot fields choose one 64K segment. Each of the two 3-bit address groups, address bits 18..16 and address bits 21..19, is decoded one-of-eight and compared with its own field. Only 22 address bits take part in the decode, so bits 23 and 22 are ignored.

Inside the chosen segment, the card holds two 16K banks. Each bank is placed independently on any 16K boundary by its own 4-position one-hot field. Storage in each bank is split into an odd-byte row and an even-byte row of 2K×8 devices, four devices per row.

The block produces the board select, a select for each bank, per-device row enables for each byte lane, and a registered copy of the board select for an activity lamp. All selection is combinational from the address and the configuration. The row enables are additionally gated by the memory strobe.

Top module: `memwin_decode`

## Requirements
- R1: Address bits 23 and 22 have no effect on any output.
- R2: Bit k (k = 0..7) of `seg_lo_sw` matches when addr[18:16] equals k, so bit 0 matches all three bits low and bit 7 matches all three bits high.
- R3: Bit k of `seg_hi_sw` matches when addr[21:19] equals k. `board_sel` is high only when both segment fields match and some bank window is hit.
- R4: If either segment field has zero or more than one bit set, `board_sel`, `bank_sel` and all row enables stay low.
- R5: For bank b, the field is `bank_sw[4b+3:4b]`. Its bit 3 places the bank at offset 0x0000 of the segment, bit 2 at 0x4000, bit 1 at 0x8000 and bit 0 at 0xC000, compared against addr[15:14]. A bank field that is not exactly one-hot never selects its bank.
- R6: When both banks claim the same window, only bank 0 is selected. `bank_sel` never has more than one bit set.
- R7: On an 8-bit access (`wide_xfer` = 0), addr[0] = 1 enables only the odd lane and addr[0] = 0 enables only the even lane.
- R8: On a 16-bit access at an even address, both lanes are enabled. At an odd address, only the odd lane is enabled.
- R9: addr[13:12] selects device d of the selected bank b. The row-enable bit index is 4b+d. Each active lane has exactly one enable set, and only while `mem_strobe` is high and `board_sel` is high.
- R10: `board_sel` and `bank_sel` follow the address and the configuration in the same cycle and do not depend on `mem_strobe`.
- R11: `board_sel_q` is 0 after a synchronous reset. After each rising clock edge it equals `board_sel && mem_strobe` as sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the activity register |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Extended bus address |
| mem_strobe | input | 1 | Memory access strobe |
| wide_xfer | input | 1 | 16-bit transfer request |
| seg_lo_sw | input | 8 | One-hot switch field for addr[18:16] |
| seg_hi_sw | input | 8 | One-hot switch field for addr[21:19] |
| bank_sw | input | 8 | Two 4-bit one-hot bank placement fields |
| board_sel | output | 1 | Card addressed |
| bank_sel | output | 2 | Bank selected, bank 0 has priority |
| odd_row_en | output | 8 | Odd-lane device enables, index 4·bank+device |
| even_row_en | output | 8 | Even-lane device enables, index 4·bank+device |
| board_sel_q | output | 1 | Registered strobed board select for the activity lamp |

## Verification
Some behaviours are checked by assertions on every cycle. These are that a segment or bank hit implies a one-hot field, that at most one bank and at most one device per lane is enabled, that row enables only appear under the strobe, that a byte access lights exactly one lane, and that the lamp register follows its strobed select. Other behaviours can only be shown by the bench's scenarios against its own model. These include the exact switch-to-address mapping, the indifference to address bits 23 and 22, the window order of the bank fields, bank 0 priority on overlap, and the lane choice for wide accesses at odd addresses.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    localparam int ADDR_W     = 24;
    localparam int GRP_W      = 3;
    localparam int GRP_POS    = 1 << GRP_W;
    localparam int SEG_LO_LSB = 16;
    localparam int SEG_HI_LSB = SEG_LO_LSB + GRP_W;
    localparam int WIN_W      = 2;
    localparam int WIN_POS    = 1 << WIN_W;
    localparam int WIN_LSB    = 14;
    localparam int DEV_W      = 2;
    localparam int DEVS       = 1 << DEV_W;
    localparam int DEV_LSB    = WIN_LSB - DEV_W;
    localparam int NUM_BANKS  = 2;

    typedef struct packed {
        logic odd;
        logic even;
    } lanes_t;

    // Byte lanes for an access: a wide access at an even address takes both.
    function automatic lanes_t lane_pick(input logic a0, input logic wide);
        lanes_t l;
        l.odd  = a0 | wide;
        l.even = ~a0;
        return l;
    endfunction

    // Switch position that claims a given 16K window (last position = window 0).
    function automatic logic [WIN_W-1:0] window_slot(input logic [WIN_W-1:0] win);
        return WIN_W'(WIN_POS - 1) - win;
    endfunction
endpackage

// File: rtl/memwin_group_match.sv
module memwin_group_match
    import memwin_pkg::*;
#(
    parameter int W = GRP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     grp,
    input  logic [(1<<W)-1:0] sw,
    output logic             hit
);
    localparam int POS = 1 << W;

    logic [POS-1:0] dec;
    logic           field_ok;

    always_comb begin
        dec = '0;
        dec[grp] = 1'b1;
    end

    assign field_ok = $onehot(sw);
    assign hit      = field_ok & (|(dec & sw));

    assert_group_field_single_R4: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($countones(sw) == 1));
endmodule

// File: rtl/memwin_bank_match.sv
module memwin_bank_match
    import memwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [WIN_W-1:0]   win,
    input  logic [WIN_POS-1:0] sw,
    output logic               hit
);
    logic [WIN_W-1:0] slot;

    assign slot = window_slot(win);
    assign hit  = $onehot(sw) & sw[slot];

    assert_bank_field_single_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($countones(sw) == 1));
endmodule

// File: rtl/memwin_lane_rows.sv
module memwin_lane_rows
    import memwin_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NB-1:0]      bank_sel,
    input  logic [DEV_W-1:0]   dev,
    input  lanes_t             lanes,
    input  logic               strobe,
    output logic [NB*DEVS-1:0] odd_en,
    output logic [NB*DEVS-1:0] even_en
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        for (genvar d = 0; d < DEVS; d++) begin : g_dev
            logic pick;
            assign pick = strobe & bank_sel[b] & (dev == DEV_W'(d));
            assign odd_en[b*DEVS+d]  = pick & lanes.odd;
            assign even_en[b*DEVS+d] = pick & lanes.even;
        end
    end

    assert_odd_single_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(odd_en));
    assert_even_single_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(even_en));
    assert_rows_need_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        ((|odd_en) || (|even_en)) |-> strobe);
endmodule

// File: rtl/memwin_decode.sv
module memwin_decode
    import memwin_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  mem_strobe,
    input  logic                  wide_xfer,
    input  logic [GRP_POS-1:0]    seg_lo_sw,
    input  logic [GRP_POS-1:0]    seg_hi_sw,
    input  logic [NB*WIN_POS-1:0] bank_sw,
    output logic                  board_sel,
    output logic [NB-1:0]         bank_sel,
    output logic [NB*DEVS-1:0]    odd_row_en,
    output logic [NB*DEVS-1:0]    even_row_en,
    output logic                  board_sel_q
);
    logic          lo_hit, hi_hit, seg_hit;
    logic [NB-1:0] bank_hit;
    lanes_t        lanes;
    logic          unused_addr_bits;

    assign unused_addr_bits = ^{addr[ADDR_W-1:SEG_HI_LSB+GRP_W], addr[DEV_LSB-1:1]};

    memwin_group_match #(.W(GRP_W)) u_seg_lo (
        .clk(clk), .rst(rst),
        .grp(addr[SEG_LO_LSB +: GRP_W]), .sw(seg_lo_sw), .hit(lo_hit));

    memwin_group_match #(.W(GRP_W)) u_seg_hi (
        .clk(clk), .rst(rst),
        .grp(addr[SEG_HI_LSB +: GRP_W]), .sw(seg_hi_sw), .hit(hi_hit));

    assign seg_hit = lo_hit & hi_hit;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        memwin_bank_match u_bank (
            .clk(clk), .rst(rst),
            .win(addr[WIN_LSB +: WIN_W]),
            .sw(bank_sw[b*WIN_POS +: WIN_POS]),
            .hit(bank_hit[b]));
    end

    // Lowest-numbered bank wins an overlapping window.
    always_comb begin
        logic claimed;
        claimed  = 1'b0;
        bank_sel = '0;
        for (int i = 0; i < NB; i++) begin
            if (seg_hit && bank_hit[i] && !claimed) begin
                bank_sel[i] = 1'b1;
                claimed     = 1'b1;
            end
        end
    end

    assign board_sel = |bank_sel;
    assign lanes     = lane_pick(addr[0], wide_xfer);

    memwin_lane_rows #(.NB(NB)) u_rows (
        .clk(clk), .rst(rst),
        .bank_sel(bank_sel),
        .dev(addr[DEV_LSB +: DEV_W]),
        .lanes(lanes),
        .strobe(mem_strobe),
        .odd_en(odd_row_en),
        .even_en(even_row_en));

    always_ff @(posedge clk) begin
        if (rst) board_sel_q <= 1'b0;
        else     board_sel_q <= board_sel & mem_strobe;
    end

    assert_bank_priority_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_sel));
    assert_select_needs_segments_R3: assert property (@(posedge clk) disable iff (rst)
        board_sel |-> (lo_hit && hi_hit));
    assert_byte_one_lane_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_strobe && board_sel && !wide_xfer) |->
            ($countones({|odd_row_en, |even_row_en}) == 1));
    assert_lamp_follows_R11: assert property (@(posedge clk) disable iff (rst)
        board_sel_q |-> $past(board_sel && mem_strobe));
    assert_bad_segment_field_R4: assert property (@(posedge clk) disable iff (rst)
        (!$onehot(seg_lo_sw) || !$onehot(seg_hi_sw)) |-> !board_sel);
endmodule

// File: tb/memwin_decode_bench.sv
module memwin_decode_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] addr;
    logic        mem_strobe, wide_xfer;
    logic [7:0]  seg_lo_sw, seg_hi_sw, bank_sw;
    logic        board_sel, board_sel_q;
    logic [1:0]  bank_sel;
    logic [7:0]  odd_row_en, even_row_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memwin_decode u_memwin_decode (
        .clk(clk), .rst(rst), .addr(addr), .mem_strobe(mem_strobe),
        .wide_xfer(wide_xfer), .seg_lo_sw(seg_lo_sw), .seg_hi_sw(seg_hi_sw),
        .bank_sw(bank_sw), .board_sel(board_sel), .bank_sel(bank_sel),
        .odd_row_en(odd_row_en), .even_row_en(even_row_en),
        .board_sel_q(board_sel_q));

    task automatic check(input string tag, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic model(output logic e_board, output logic [1:0] e_bank,
                         output logic [7:0] e_odd, output logic [7:0] e_even);
        logic seg_ok, h0, h1, lane_o, lane_e;
        int   w, bi, dv;
        seg_ok = ($countones(seg_lo_sw) == 1) && seg_lo_sw[addr[18:16]] &&
                 ($countones(seg_hi_sw) == 1) && seg_hi_sw[addr[21:19]];
        w  = addr[15:14];
        h0 = ($countones(bank_sw[3:0]) == 1) && bank_sw[3 - w];
        h1 = ($countones(bank_sw[7:4]) == 1) && bank_sw[4 + 3 - w];
        e_bank  = !seg_ok ? 2'b00 : h0 ? 2'b01 : h1 ? 2'b10 : 2'b00;
        e_board = |e_bank;
        bi = e_bank[1] ? 1 : 0;
        dv = addr[13:12];
        lane_o = addr[0] | wide_xfer;
        lane_e = ~addr[0];
        e_odd  = (mem_strobe && e_board && lane_o) ? 8'(1 << (bi*4 + dv)) : 8'h00;
        e_even = (mem_strobe && e_board && lane_e) ? 8'(1 << (bi*4 + dv)) : 8'h00;
    endtask

    // Inputs already applied after a falling edge; checks combinational
    // outputs, then the lamp register after the next rising edge.
    task automatic run_vec(input string tag);
        logic eb; logic [1:0] ebk; logic [7:0] eo, ee;
        #1;
        model(eb, ebk, eo, ee);
        check(tag, "board_sel", {7'b0, board_sel}, {7'b0, eb});
        check(tag, "bank_sel", {6'b0, bank_sel}, {6'b0, ebk});
        check(tag, "odd_row_en", odd_row_en, eo);
        check(tag, "even_row_en", even_row_en, ee);
        @(posedge clk);
        @(negedge clk);
        check("R11", "board_sel_q", {7'b0, board_sel_q}, {7'b0, eb & mem_strobe});
    endtask

    task automatic drive(input logic [23:0] a, input logic stb, input logic wd);
        addr = a; mem_strobe = stb; wide_xfer = wd;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  s0, s1;
        logic [23:0] a0, a1;
        logic        b0, b1;
        logic [1:0]  k0, k1;
        void'($urandom(32'd2718));
        rst = 1'b1;
        drive(24'h0, 1'b0, 1'b0);
        seg_lo_sw = 8'h01; seg_hi_sw = 8'h01; bank_sw = 8'b0100_1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "board_sel_q after reset", {7'b0, board_sel_q}, 8'h00);
        rst = 1'b0;

        // R5 default placement: bank 0 at 0x0000, bank 1 at 0x4000
        drive(24'h000000, 1'b1, 1'b0); run_vec("R5");
        drive(24'h007FFF, 1'b1, 1'b0); run_vec("R9");
        drive(24'h003000, 1'b1, 1'b0); run_vec("R9");
        drive(24'h008000, 1'b1, 1'b0); run_vec("R5");
        drive(24'h00C001, 1'b1, 1'b0); run_vec("R5");

        // R1 bits 23 and 22 ignored: compare directly with base address
        drive(24'h002345, 1'b1, 1'b0); #1;
        s0 = odd_row_en; s1 = even_row_en; b0 = board_sel; k0 = bank_sel;
        drive(24'hC02345, 1'b1, 1'b0); #1;
        check("R1", "odd_row_en", odd_row_en, s0);
        check("R1", "even_row_en", even_row_en, s1);
        check("R1", "board_sel", {7'b0, board_sel}, {7'b0, b0});
        check("R1", "bank_sel", {6'b0, bank_sel}, {6'b0, k0});
        check("R1", "board_sel expected high", {7'b0, board_sel}, 8'h01);
        @(negedge clk);

        // R2 / R3 segment mapping at both ends of each group
        seg_lo_sw = 8'h20; seg_hi_sw = 8'h80;
        drive(24'h3D4000, 1'b1, 1'b0); run_vec("R2");
        drive(24'h3C4000, 1'b1, 1'b0); run_vec("R2");
        drive(24'h354000, 1'b1, 1'b0); run_vec("R3");
        seg_lo_sw = 8'h80; seg_hi_sw = 8'h01;
        drive(24'h070000, 1'b1, 1'b0); run_vec("R2");

        // R4 misconfigured segment fields
        seg_lo_sw = 8'h00; seg_hi_sw = 8'h01;
        drive(24'h000000, 1'b1, 1'b0); run_vec("R4");
        seg_lo_sw = 8'h03;
        drive(24'h010000, 1'b1, 1'b0); run_vec("R4");
        seg_lo_sw = 8'h01; seg_hi_sw = 8'h11;
        drive(24'h000000, 1'b1, 1'b0); run_vec("R4");
        seg_hi_sw = 8'h01;

        // R5 invalid bank field and high windows
        bank_sw = 8'b0001_1100;
        drive(24'h000000, 1'b1, 1'b0); run_vec("R5");
        drive(24'h00F000, 1'b1, 1'b0); run_vec("R5");
        bank_sw = 8'b0001_0010;
        drive(24'h008800, 1'b1, 1'b1); run_vec("R5");

        // R6 overlapping banks
        bank_sw = 8'b1000_1000;
        drive(24'h001001, 1'b1, 1'b0); run_vec("R6");
        check("R6", "bank_sel only bank 0", {6'b0, bank_sel}, 8'h01);

        // R7 / R8 lanes
        bank_sw = 8'b0100_1000;
        drive(24'h002000, 1'b1, 1'b0); run_vec("R7");
        drive(24'h002001, 1'b1, 1'b0); run_vec("R7");
        drive(24'h006000, 1'b1, 1'b1); run_vec("R8");
        check("R8", "both lanes", {6'b0, |odd_row_en, |even_row_en}, 8'h03);
        drive(24'h006001, 1'b1, 1'b1); run_vec("R8");

        // R10 strobe low: selects stay, rows off
        drive(24'h005000, 1'b0, 1'b0); run_vec("R10");
        check("R10", "board_sel without strobe", {7'b0, board_sel}, 8'h01);

        // Random configurations and addresses
        for (int n = 0; n < 600; n++) begin
            int lo_i, hi_i;
            lo_i = $urandom_range(7); hi_i = $urandom_range(7);
            seg_lo_sw = ($urandom_range(7) == 0) ? 8'($urandom) : 8'(1 << lo_i);
            seg_hi_sw = ($urandom_range(7) == 0) ? 8'($urandom) : 8'(1 << hi_i);
            bank_sw[3:0] = ($urandom_range(7) == 0) ? 4'($urandom)
                                                    : 4'(1 << $urandom_range(3));
            bank_sw[7:4] = ($urandom_range(7) == 0) ? 4'($urandom)
                                                    : 4'(1 << $urandom_range(3));
            a0 = 24'($urandom);
            if ($urandom_range(3) != 0) begin
                a0[18:16] = 3'(lo_i);
                a0[21:19] = 3'(hi_i);
            end
            a1 = a0;
            drive(a1, 1'($urandom), 1'($urandom));
            run_vec("R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule